// File: doc/BRIEF.md
# Skip-Test Arithmetic Unit

This block is the arithmetic stage of a small word-oriented processor datapath. Two 32-bit operand registers capture a value from a shared input bus when their load strobes are high. A 2-bit function select picks one of four operations on the held operands: addition, subtraction, bitwise NAND, or increment of the first operand. The result appears on the output port only while the drive enable is high. Otherwise the port reads zero, so an external bus merge can OR several sources together.

Next to the arithmetic logic, a purely combinational comparator looks at the current result and a 1-bit mode taken from the instruction, and decides whether a skip condition holds. The controller runs a subtraction and raises the compare-load strobe. On that edge the decision is latched into a 1-bit condition register, and the sequencer uses that register to choose between the fall-through state and the skip state.

Control pins are plain level strobes sampled at the rising clock edge. The block applies no valid/ready handshake and no back-pressure. The controller owns the sequencing and must not expect the unit to stall.

Top module: `skipalu_unit`

## Requirements
- R1: After reset, both operand registers hold zero and the condition register is 0. With the add function and drive enabled, the output therefore reads 0.
- R2: On a rising edge with `ld_a` (or `ld_b`) high, operand A (or B) takes the value of `bus_in`. Without its strobe, an operand register keeps its value.
- R3: Function code 2'b00 gives A+B, modulo 2^32.
- R4: Function code 2'b01 gives A−B, modulo 2^32.
- R5: Function code 2'b10 gives the bitwise NOT of (A AND B).
- R6: Function code 2'b11 gives A+1, and operand B has no effect on the result.
- R7: While `drive_alu` is low, `alu_out` is all zeros whatever the operands and function.
- R8: Mode 0 (`cmp_mode`=0) evaluates true exactly when the result is nonzero. Under subtraction, this means A≠B.
- R9: Mode 1 (`cmp_mode`=1) treats A and B as signed two's complement values. It evaluates true exactly when the result is zero or the overflow-corrected sign of A−B is set, which means A≤B. This holds even when the subtraction overflows.
- R10: `cond_q` takes the comparator decision on a rising edge with `ld_cmp` high, and holds its value on every other edge.
- R11: With `ld_a` and `ld_b` both high on the same edge, both operands capture the same bus value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_in | input | 32 | Shared bus value offered to the operand registers |
| ld_a | input | 1 | Load operand A from `bus_in` |
| ld_b | input | 1 | Load operand B from `bus_in` |
| fn_sel | input | 2 | Function select: 00 add, 01 subtract, 10 NAND, 11 increment A |
| cmp_mode | input | 1 | Comparison mode: 0 not-equal, 1 signed less-or-equal |
| ld_cmp | input | 1 | Capture the comparator decision into `cond_q` |
| drive_alu | input | 1 | Present the result on `alu_out`; zero when low |
| alu_out | output | 32 | Gated result |
| cond_q | output | 1 | Registered skip decision for the sequencer |

## Verification
A corrupted operand register shows at `alu_out` in the same cycle it is read. That read comes one edge after the bad load or the missed hold. A wrong comparator decision stays hidden until a compare-load edge, and then it sits on `cond_q` from the following cycle until the next compare-load. The overflow cases of the signed test therefore need vectors whose operands differ in sign. Loss of the hold on `cond_q` only shows when the operands change between compare-loads.

// File: rtl/skipalu_pkg.sv
package skipalu_pkg;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [1:0] {
    FN_ADD  = 2'b00,
    FN_SUB  = 2'b01,
    FN_NAND = 2'b10,
    FN_INC  = 2'b11
  } alu_fn_e;
endpackage

// File: rtl/skipalu_core.sv
module skipalu_core
  import skipalu_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  alu_fn_e      fn,
  output logic [W-1:0] res,
  output logic         sub_ovf
);
  localparam int unsigned MSB = W - 1;

  logic [W-1:0] diff;

  // difference kept separate so its overflow can be judged on its own
  assign diff = opa - opb;

  always_comb begin
    unique case (fn)
      FN_ADD:  res = opa + opb;
      FN_SUB:  res = diff;
      FN_NAND: res = ~(opa & opb);
      FN_INC:  res = opa + {{(W-1){1'b0}}, 1'b1};
      default: res = '0;
    endcase
  end

  // signed overflow of A-B: operands of unlike sign, result sign unlike A
  assign sub_ovf = (fn == FN_SUB) && (opa[MSB] != opb[MSB]) && (diff[MSB] != opa[MSB]);
endmodule

// File: rtl/skipalu_cmp.sv
module skipalu_cmp #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] res,
  input  logic         ovf,
  input  logic         mode,
  output logic         cond
);
  localparam int unsigned MSB = W - 1;

  logic is_zero;
  logic neg_true;

  assign is_zero  = (res == '0);
  assign neg_true = res[MSB] ^ ovf;

  always_comb begin
    if (mode) cond = is_zero | neg_true;
    else      cond = ~is_zero;
  end
endmodule

// File: rtl/skipalu_unit.sv
module skipalu_unit
  import skipalu_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] bus_in,
  input  logic         ld_a,
  input  logic         ld_b,
  input  logic [1:0]   fn_sel,
  input  logic         cmp_mode,
  input  logic         ld_cmp,
  input  logic         drive_alu,
  output logic [W-1:0] alu_out,
  output logic         cond_q
);
  logic [W-1:0] opa_q;
  logic [W-1:0] opb_q;
  logic [W-1:0] res;
  logic         sub_ovf;
  logic         cmp_true;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opa_q <= '0;
      opb_q <= '0;
    end else begin
      if (ld_a) opa_q <= bus_in;
      if (ld_b) opb_q <= bus_in;
    end
  end

  skipalu_core #(.W(W)) u_core (
    .opa     (opa_q),
    .opb     (opb_q),
    .fn      (alu_fn_e'(fn_sel)),
    .res     (res),
    .sub_ovf (sub_ovf)
  );

  skipalu_cmp #(.W(W)) u_cmp (
    .res  (res),
    .ovf  (sub_ovf),
    .mode (cmp_mode),
    .cond (cmp_true)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      cond_q <= 1'b0;
    else if (ld_cmp) cond_q <= cmp_true;
  end

  assign alu_out = drive_alu ? res : '0;

  assert_load_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_a |=> (opa_q == $past(bus_in)));

  assert_hold_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_b |=> $stable(opb_q));

  assert_cond_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_cmp |=> $stable(cond_q));

  assert_ne_test_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_cmp && fn_sel == FN_SUB && !cmp_mode) |=>
      (cond_q == ($past(opa_q) != $past(opb_q))));

  assert_le_test_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_cmp && fn_sel == FN_SUB && cmp_mode) |=>
      (cond_q == ($signed($past(opa_q)) <= $signed($past(opb_q)))));
endmodule

// File: tb/skipalu_unit_tb.sv
module skipalu_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;
  localparam int NVEC       = 12;

  // {A, B, fn, mode, expected result, expected cond}
  localparam logic [99:0] VECS [NVEC] = '{
    {32'h00000005, 32'h00000007, 2'b00, 1'b0, 32'h0000000C, 1'b1}, // R3 R8
    {32'hFFFFFFFF, 32'h00000001, 2'b00, 1'b0, 32'h00000000, 1'b0}, // R3 wrap
    {32'h0000000A, 32'h00000003, 2'b01, 1'b1, 32'h00000007, 1'b0}, // R4 R9
    {32'h00000003, 32'h0000000A, 2'b01, 1'b1, 32'hFFFFFFF9, 1'b1}, // R4 R9
    {32'h00000005, 32'h00000005, 2'b01, 1'b0, 32'h00000000, 1'b0}, // R8 equal
    {32'h00000005, 32'h00000005, 2'b01, 1'b1, 32'h00000000, 1'b1}, // R9 equal
    {32'h80000000, 32'h00000001, 2'b01, 1'b1, 32'h7FFFFFFF, 1'b1}, // R9 ovf
    {32'h7FFFFFFF, 32'hFFFFFFFF, 2'b01, 1'b1, 32'h80000000, 1'b0}, // R9 ovf
    {32'h7FFFFFFF, 32'h80000000, 2'b01, 1'b0, 32'hFFFFFFFF, 1'b1}, // R8
    {32'hF0F0F0F0, 32'hFF00FF00, 2'b10, 1'b1, 32'h0FFF0FFF, 1'b0}, // R5
    {32'h7FFFFFFF, 32'h12345678, 2'b11, 1'b1, 32'h80000000, 1'b1}, // R6
    {32'h00000002, 32'hFFFFFFFD, 2'b01, 1'b0, 32'h00000005, 1'b1}  // R4 R8
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] bus_in;
  logic        ld_a, ld_b, ld_cmp, drive_alu, cmp_mode;
  logic [1:0]  fn_sel;
  logic [31:0] alu_out;
  logic        cond_q;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  skipalu_unit u_dut (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .ld_a(ld_a), .ld_b(ld_b),
    .fn_sel(fn_sel), .cmp_mode(cmp_mode), .ld_cmp(ld_cmp),
    .drive_alu(drive_alu), .alu_out(alu_out), .cond_q(cond_q)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected <= %0d", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [31:0] v, input logic la, input logic lb);
    @(negedge clk);
    bus_in = v; ld_a = la; ld_b = lb;
    @(negedge clk);
    ld_a = 1'b0; ld_b = 1'b0; bus_in = 32'hDEADBEEF;
  endtask

  task automatic compare(input logic [1:0] fn, input logic md);
    @(negedge clk);
    fn_sel = fn; cmp_mode = md; ld_cmp = 1'b1;
    @(negedge clk);
    ld_cmp = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; bus_in = '0; ld_a = 0; ld_b = 0; ld_cmp = 0;
    drive_alu = 1'b1; cmp_mode = 0; fn_sel = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 result after reset", alu_out, 32'h0);
    chk("R1 cond after reset", {31'b0, cond_q}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      load(VECS[i][99:68], 1'b1, 1'b0);
      load(VECS[i][67:36], 1'b0, 1'b1);
      compare(VECS[i][35:34], VECS[i][33]);
      chk($sformatf("R3-6 result vec %0d", i), alu_out, VECS[i][32:1]);
      chk($sformatf("R8/R9 cond vec %0d", i), {31'b0, cond_q}, {31'b0, VECS[i][0]});
    end

    // R6: B has no effect on increment
    load(32'h00000010, 1'b1, 1'b0);
    load(32'hFFFFFFFF, 1'b0, 1'b1);
    fn_sel = 2'b11;
    @(negedge clk);
    chk("R6 increment ignores B", alu_out, 32'h00000011);

    // R7: drive low forces zero
    drive_alu = 1'b0;
    @(negedge clk);
    chk("R7 drive low", alu_out, 32'h0);
    drive_alu = 1'b1;

    // R2: operands hold without strobes
    repeat (3) @(negedge clk);
    chk("R2 hold A", alu_out, 32'h00000011);
    fn_sel = 2'b00;
    @(negedge clk);
    chk("R2 hold B", alu_out, 32'h0000000F);

    // R10: cond holds while operands change, ld_cmp low
    load(32'h00000004, 1'b1, 1'b0);
    load(32'h00000004, 1'b0, 1'b1);
    compare(2'b01, 1'b0);
    chk("R10 cond captured", {31'b0, cond_q}, 32'h0);
    load(32'h00000009, 1'b1, 1'b0);
    fn_sel = 2'b01; cmp_mode = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 cond held", {31'b0, cond_q}, 32'h0);

    // R11: simultaneous load
    load(32'h00000009, 1'b1, 1'b1);
    fn_sel = 2'b01;
    @(negedge clk);
    chk("R11 both loaded, diff", alu_out, 32'h0);
    fn_sel = 2'b00;
    @(negedge clk);
    chk("R11 both loaded, sum", alu_out, 32'h00000012);

    // R1: reset again clears operands and cond
    compare(2'b01, 1'b1);
    chk("R9 equal sets cond", {31'b0, cond_q}, 32'h1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    fn_sel = 2'b00;
    @(negedge clk);
    chk("R1 re-reset result", alu_out, 32'h0);
    chk("R1 re-reset cond", {31'b0, cond_q}, 32'h0);

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule